// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This engine carries the data phase of a write to an SD card in SPI mode. The write command is issued elsewhere. Once that command has been answered, a single `start` pulse hands over three inputs: how many blocks to send, the size of each block in bytes, and whether the transfer is a multi-block write. The engine then owns a byte-exchange port, where each exchange sends one byte and returns one byte. It also owns an input byte stream that supplies the payload.

For each block the engine does the following, in order:
- Sends a filler byte, then the start token that matches the mode.
- Streams the payload and follows it with a CRC16 that it computes on the fly.
- Reads the card's data-response byte and decodes it.
- Polls the card until the card stops signalling busy.

A multi-block write that completes without error ends with a filler, a stop-transfer token and one last busy wait. When the engine finishes, it presents a one-byte status in the same cycle as a one-cycle `done` pulse.

Top module: `sd_spi_block_writer`

## Requirements
- R1: During and straight after reset: `busy`, `done`, `xfer_req` and `in_ready` are 0, and `status` is 0x00.
- R2: Every block begins with the byte 0xFF. The next byte is the start token: 0xFE when `multi` was 0 at start, 0xFC when it was 1. While `xfer_req` waits for `xfer_ack` outside the payload, `xfer_tx` holds steady.
- R3: The payload bytes go out in stream order, exactly `blk_size` of them per block. A byte counts as consumed only in the cycle its exchange is acknowledged, which is the cycle `in_ready` is high. While `in_valid` is low, no payload exchange is requested.
- R4: After the payload come two bytes: a CRC16 with polynomial 0x1021 and initial value 0 over that block's payload, high byte first. The CRC starts again from zero for every block.
- R5: After the CRC, the engine reads the response by sending 0xFF. It stops at the first byte with bit 4 clear, or after 8 reads. If that byte's low five bits are 0x05, the block is accepted. Any other value (such as 0x0B or 0x0D) ends the transfer at once with status 0x08 and no further exchange.
- R6: After an accepted block, the engine reads bytes (sending 0xFF) until it sees 0xFF; the first read of a wait never ends it. If BUSY_LIMIT reads pass without that, the transfer ends with status 0x80 and no further exchange.
- R7: A multi-block write whose blocks were all accepted and released then sends 0xFF, then 0xFD, then performs the R6 wait. It ends with status 0x00, or 0x80 on timeout.
- R8: A transfer that ends without error reports status 0x00. `done` is high for exactly one cycle, with `status` valid in that cycle. `busy` is high from the cycle after `start` until the cycle after `done`.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the transfer in progress.
- R10: A block count of 0 sends no block. In single mode the engine finishes with status 0x00 and makes no exchange. In multi mode it performs only the R7 stop sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled only while idle) |
| blk_count | input | CNT_W | Number of blocks to write |
| blk_size | input | SIZE_W | Bytes per block |
| multi | input | 1 | 1 = multi-block write, 0 = single-block write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| status | output | 8 | 0x00 ok, 0x08 rejected response, 0x80 busy timeout |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Payload byte consumed this cycle |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Exchange complete; `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received |

## Verification
Two events can land in the same cycle. One is the acknowledgement of a payload exchange, which is also the cycle the stream byte is consumed. The other is the stream source withdrawing `in_valid` just after a byte is taken. The bench provokes this overlap by delaying every fourth acknowledgement and by opening two-cycle gaps in the stream after each accepted byte. It then judges the result by comparing the full sent-byte log with a sequence built from the requirements, where a skipped, repeated or garbage byte shows up as a mismatch. A second pulse of `start`, with different parameters, is also placed in the middle of a busy transfer; the byte log and the status must still match the first request.

// File: rtl/sd_wr_pkg.sv
// Shared constants, state type and CRC step for the SD SPI block writer.
// Assumes byte-wide exchanges; the CRC is CCITT polynomial 0x1021, MSB first.
package sd_wr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FILL,
        ST_TOKEN,
        ST_DATA,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_RESP,
        ST_BUSY,
        ST_STOP_FILL,
        ST_STOP_TOK,
        ST_STOP_BUSY,
        ST_DONE
    } wr_state_t;

    localparam logic [7:0] FILLER      = 8'hFF;
    localparam logic [7:0] TOK_SINGLE  = 8'hFE;
    localparam logic [7:0] TOK_MULTI   = 8'hFC;
    localparam logic [7:0] TOK_STOP    = 8'hFD;
    localparam logic [4:0] RESP_ACCEPT = 5'h05;
    localparam logic [7:0] STAT_OK     = 8'h00;
    localparam logic [7:0] STAT_CRC    = 8'h08;
    localparam logic [7:0] STAT_TMO    = 8'h80;
    localparam logic [15:0] CRC_POLY   = 16'h1021;

    // Advance a CRC16 by one byte, most significant bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/sd_wr_crc16.sv
// Running CRC16 over the payload of one block.
// Assumes clear and en are never asserted together; clear wins if they are.
module sd_wr_crc16 import sd_wr_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Accumulate one byte per accepted payload exchange.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc <= '0;
        else if (clear) crc <= '0;
        else if (en)    crc <= crc16_byte(crc, din);
    end

    // R4
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == 16'h0000));

endmodule

// File: rtl/sd_wr_poll.sv
// Read counter for a bounded polling loop.
// Counts reads since clear; first marks read 0, last marks read LIMIT-1.
// Assumes the owner stops stepping once last is reached.
module sd_wr_poll #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic first,
    output logic last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count polling reads, restarting whenever the loop is not active.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= cnt + CW'(1);
    end

    assign first = (cnt == '0);
    assign last  = (cnt == CW'(LIMIT - 1));

    // R6
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LIMIT));

endmodule

// File: rtl/sd_spi_block_writer.sv
// Data phase of an SD card SPI-mode write: tokens, payload, CRC16,
// data-response decode, busy polling and the multi-block stop token.
// Assumes the write command was already answered, that xfer_ack comes only
// while xfer_req is high, and that in_valid stays high until in_ready.
module sd_spi_block_writer import sd_wr_pkg::*; #(
    parameter int CNT_W      = 16,
    parameter int SIZE_W     = 12,
    parameter int BUSY_LIMIT = 3000000,
    parameter int RESP_TRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic              multi,
    output logic              busy,
    output logic              done,
    output logic [7:0]        status,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx
);

    wr_state_t         state, state_nx;
    logic [CNT_W-1:0]  blk_left, blk_nx;
    logic [SIZE_W-1:0] byte_left, byte_nx;
    logic [SIZE_W-1:0] size_q;
    logic              multi_q;
    logic [7:0]        status_q, status_nx;
    logic [15:0]       crc;
    logic              xchg;
    logic              resp_step, resp_first, resp_last;
    logic              busy_step, busy_first, busy_last;
    logic              in_busy_wait;

    assign xchg         = xfer_req && xfer_ack;
    assign in_busy_wait = (state == ST_BUSY) || (state == ST_STOP_BUSY);

    sd_wr_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_TOKEN),
        .en    (xchg && (state == ST_DATA)),
        .din   (in_data),
        .crc   (crc)
    );

    sd_wr_poll #(.LIMIT(RESP_TRIES)) u_resp_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != ST_RESP),
        .step  (resp_step),
        .first (resp_first),
        .last  (resp_last)
    );

    sd_wr_poll #(.LIMIT(BUSY_LIMIT)) u_busy_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_busy_wait),
        .step  (busy_step),
        .first (busy_first),
        .last  (busy_last)
    );

    // Exchange request and the byte sent in each state.
    always_comb begin
        xfer_req = 1'b1;
        xfer_tx  = FILLER;
        unique case (state)
            ST_IDLE, ST_DONE: xfer_req = 1'b0;
            ST_TOKEN:         xfer_tx  = multi_q ? TOK_MULTI : TOK_SINGLE;
            ST_DATA: begin
                xfer_req = in_valid;
                xfer_tx  = in_data;
            end
            ST_CRC_HI:        xfer_tx  = crc[15:8];
            ST_CRC_LO:        xfer_tx  = crc[7:0];
            ST_STOP_TOK:      xfer_tx  = TOK_STOP;
            default:          xfer_tx  = FILLER;
        endcase
    end

    assign in_ready = (state == ST_DATA) && xfer_ack;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign status   = status_q;

    // Sequencing: next state, counters and final status.
    always_comb begin
        state_nx  = state;
        status_nx = status_q;
        blk_nx    = blk_left;
        byte_nx   = byte_left;
        resp_step = 1'b0;
        busy_step = 1'b0;
        unique case (state)
            ST_IDLE: if (start) begin
                status_nx = STAT_OK;
                blk_nx    = blk_count;
                if (blk_count == '0) state_nx = multi ? ST_STOP_FILL : ST_DONE;
                else                 state_nx = ST_FILL;
            end
            ST_FILL: if (xchg) state_nx = ST_TOKEN;
            ST_TOKEN: if (xchg) begin
                byte_nx  = size_q;
                state_nx = (size_q == '0) ? ST_CRC_HI : ST_DATA;
            end
            ST_DATA: if (xchg) begin
                byte_nx = byte_left - SIZE_W'(1);
                if (byte_left == SIZE_W'(1)) state_nx = ST_CRC_HI;
            end
            ST_CRC_HI: if (xchg) state_nx = ST_CRC_LO;
            ST_CRC_LO: if (xchg) state_nx = ST_RESP;
            ST_RESP: if (xchg) begin
                if (!xfer_rx[4] || resp_last) begin
                    if (xfer_rx[4:0] == RESP_ACCEPT) begin
                        state_nx = ST_BUSY;
                    end else begin
                        status_nx = STAT_CRC;
                        state_nx  = ST_DONE;
                    end
                end else begin
                    resp_step = 1'b1;
                end
            end
            ST_BUSY: if (xchg) begin
                if (!busy_first && xfer_rx == FILLER) begin
                    if (blk_left == CNT_W'(1)) begin
                        state_nx = multi_q ? ST_STOP_FILL : ST_DONE;
                    end else begin
                        blk_nx   = blk_left - CNT_W'(1);
                        state_nx = ST_FILL;
                    end
                end else if (busy_last) begin
                    status_nx = STAT_TMO;
                    state_nx  = ST_DONE;
                end else begin
                    busy_step = 1'b1;
                end
            end
            ST_STOP_FILL: if (xchg) state_nx = ST_STOP_TOK;
            ST_STOP_TOK:  if (xchg) state_nx = ST_STOP_BUSY;
            ST_STOP_BUSY: if (xchg) begin
                if (!busy_first && xfer_rx == FILLER) begin
                    state_nx = ST_DONE;
                end else if (busy_last) begin
                    status_nx = STAT_TMO;
                    state_nx  = ST_DONE;
                end else begin
                    busy_step = 1'b1;
                end
            end
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            status_q  <= STAT_OK;
            blk_left  <= '0;
            byte_left <= '0;
        end else begin
            state     <= state_nx;
            status_q  <= status_nx;
            blk_left  <= blk_nx;
            byte_left <= byte_nx;
        end
    end

    // Transfer parameters, captured only when a start is taken while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q  <= '0;
            multi_q <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            size_q  <= blk_size;
            multi_q <= multi;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R5
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status == STAT_OK || status == STAT_CRC || status == STAT_TMO));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack && state != ST_DATA) |=> (xfer_req && $stable(xfer_tx)));

endmodule

// File: tb/sd_spi_block_writer_test.sv
// Directed bench: a scripted card answers the exchange port, a source feeds payload.
module sd_spi_block_writer_test;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 16;
    localparam int MAXB       = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] blk_count = '0;
    logic [11:0] blk_size = '0;
    logic        multi = 1'b0;
    logic        busy, done, in_ready, xfer_req;
    logic [7:0]  status, xfer_tx;
    logic [7:0]  in_data = 8'h00;
    logic        in_valid = 1'b0;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;

    logic [7:0] exp_tx [0:MAXB-1];
    logic [7:0] rx_s   [0:MAXB-1];
    logic [7:0] log_tx [0:MAXB-1];
    logic [7:0] src_mem[0:MAXB-1];
    int exp_len = 0, log_len = 0, src_len = 0, src_idx = 0;
    int n_chk = 0, n_err = 0, done_cnt = 0, gap = 0;
    bit src_took = 0, waited = 0, gap_mode = 0, pulse_req = 0, done_flag = 0;
    logic [7:0] stat_cap = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_spi_block_writer #(.CNT_W(16), .SIZE_W(12), .BUSY_LIMIT(LIMIT), .RESP_TRIES(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .blk_size(blk_size), .multi(multi), .busy(busy), .done(done),
        .status(status), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    // Drive at the falling edge, sample a quarter period before the rising edge.
    initial forever begin
        @(negedge clk);
        start = pulse_req;
        pulse_req = 0;
        if (xfer_ack) begin
            xfer_ack = 1'b0;
        end else if (xfer_req) begin
            if (log_len % 4 == 2 && !waited) begin
                waited = 1;
            end else begin
                waited = 0;
                xfer_ack = 1'b1;
                xfer_rx = (log_len < exp_len) ? rx_s[log_len] : 8'hFF;
            end
        end
        if (src_took) begin
            src_idx++;
            gap = gap_mode ? 2 : 0;
        end
        if (gap > 0) begin
            gap--;
            in_valid = 1'b0;
            in_data = 8'h00;
        end else if (src_idx < src_len) begin
            in_valid = 1'b1;
            in_data = src_mem[src_idx];
        end else begin
            in_valid = 1'b0;
            in_data = 8'h00;
        end
        #(CLK_PERIOD/4);
        src_took = in_valid && in_ready;
        if (xfer_ack && log_len < MAXB) begin
            log_tx[log_len] = xfer_tx;
            log_len++;
        end
        if (done) begin
            done_flag = 1;
            done_cnt++;
            stat_cap = status;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c = c_in;
        for (int i = 7; i >= 0; i--) begin
            logic fb = c[15] ^ d[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic new_case();
        exp_len = 0;
        src_len = 0;
    endtask

    task automatic add(input logic [7:0] t, input logic [7:0] r);
        exp_tx[exp_len] = t;
        rx_s[exp_len] = r;
        exp_len++;
    endtask

    // Expected bytes of one block: filler, token, payload, CRC (R2, R3, R4).
    task automatic blk(input logic [7:0] tok, input int size, input int seed, input bit all_ff);
        logic [15:0] c = 16'h0000;
        add(8'hFF, 8'hFF);
        add(tok, 8'hFF);
        for (int i = 0; i < size; i++) begin
            logic [7:0] d = all_ff ? 8'hFF : 8'((seed + i * 37) & 255);
            src_mem[src_len] = d;
            src_len++;
            c = crc_step(c, d);
            add(d, 8'hFF);
        end
        add(c[15:8], 8'hFF);
        add(c[7:0], 8'hFF);
    endtask

    task automatic resp(input int pre, input logic [7:0] code);
        for (int i = 0; i < pre; i++) add(8'hFF, 8'hFF);
        add(8'hFF, code);
    endtask

    task automatic busyw(input logic [7:0] first, input int zeros);
        add(8'hFF, first);
        for (int i = 0; i < zeros; i++) add(8'hFF, 8'h00);
        add(8'hFF, 8'hFF);
    endtask

    task automatic stop_seq();
        add(8'hFF, 8'hFF);
        add(8'hFD, 8'hFF);
    endtask

    task automatic run(input int cnt, input int size, input bit mul, input bit second,
                       input logic [7:0] exp_stat, input string req);
        int cyc = 0;
        int bad = -1;
        log_len = 0; src_idx = 0; src_took = 0; gap = 0;
        done_flag = 0; done_cnt = 0; waited = 0;
        blk_count = 16'(cnt); blk_size = 12'(size); multi = mul;
        pulse_req = 1;
        while (!done_flag && cyc < 20000) begin
            @(posedge clk);
            #1;
            cyc++;
            if (cyc == 3) chk(busy === 1'b1, "R8", busy, 1, "busy during transfer");
            if (second && cyc == 12) begin
                blk_count = 16'd1; blk_size = 12'd9; multi = 1'b0;
                pulse_req = 1;
            end
        end
        if (!done_flag) chk(0, req, 0, 1, "watchdog expired");
        repeat (6) @(posedge clk);
        #1;
        for (int i = 0; i < exp_len && i < log_len; i++)
            if (bad < 0 && log_tx[i] !== exp_tx[i]) bad = i;
        chk(bad < 0, req, (bad >= 0) ? int'(log_tx[bad]) : 0,
            (bad >= 0) ? int'(exp_tx[bad]) : 0, $sformatf("sent byte %0d", bad));
        chk(log_len == exp_len, req, log_len, exp_len, "exchange count");
        chk(stat_cap === exp_stat, req, stat_cap, exp_stat, "status");
        chk(done_cnt == 1, "R8", done_cnt, 1, "done pulse width");
        chk(busy === 1'b0, "R8", busy, 0, "idle after done");
    endtask

    // R1: outputs while held in reset and just after release.
    task automatic t_reset();
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        chk(busy === 0 && done === 0, "R1", {busy, done}, 0, "busy/done in reset");
        chk(xfer_req === 0 && in_ready === 0, "R1", {xfer_req, in_ready}, 0, "req/ready in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk(status === 8'h00 && busy === 0, "R1", status, 0, "status after reset");
    endtask

    // R2 R3 R4 R5 R6 R8: one block, first busy read 0xFF must be ignored.
    task automatic t_single();
        new_case(); gap_mode = 0;
        blk(8'hFE, 4, 3, 0); resp(0, 8'hE5); busyw(8'hFF, 2);
        run(1, 4, 0, 0, 8'h00, "R2_single");
    endtask

    // R3 R7: three multi blocks with stream gaps and late responses.
    task automatic t_multi_gaps();
        new_case(); gap_mode = 1;
        for (int b = 0; b < 3; b++) begin
            blk(8'hFC, 5, 11 * b + 1, 0); resp(2, 8'h05); busyw(8'h00, 1);
        end
        stop_seq(); busyw(8'h00, 3);
        run(3, 5, 1, 0, 8'h00, "R7_multi");
        gap_mode = 0;
    endtask

    // R5: second block rejected with 0x0B, no stop token afterwards.
    task automatic t_crc_reject();
        new_case();
        blk(8'hFC, 3, 40, 0); resp(0, 8'h05); busyw(8'h00, 0);
        blk(8'hFC, 3, 90, 0); resp(1, 8'h0B);
        run(3, 3, 1, 0, 8'h08, "R5_reject");
    endtask

    // R5: write error code 0x0D in single mode.
    task automatic t_write_err();
        new_case();
        blk(8'hFE, 6, 7, 0); resp(0, 8'h0D);
        run(1, 6, 0, 0, 8'h08, "R5_wrerr");
    endtask

    // R5: no byte with bit 4 clear in 8 reads.
    task automatic t_no_resp();
        new_case();
        blk(8'hFE, 2, 5, 0); resp(7, 8'hFF);
        run(1, 2, 0, 0, 8'h08, "R5_noresp");
    endtask

    // R6: busy never released within LIMIT reads.
    task automatic t_busy_tmo();
        new_case();
        blk(8'hFE, 2, 9, 0); resp(0, 8'h05);
        for (int i = 0; i < LIMIT; i++) add(8'hFF, 8'h00);
        run(1, 2, 0, 0, 8'h80, "R6_timeout");
    endtask

    // R7 R6: timeout during the wait after the stop token.
    task automatic t_stop_tmo();
        new_case();
        blk(8'hFC, 3, 21, 0); resp(0, 8'h05); busyw(8'h00, 2);
        stop_seq();
        for (int i = 0; i < LIMIT; i++) add(8'hFF, 8'h00);
        run(1, 3, 1, 0, 8'h80, "R7_stoptmo");
    endtask

    // R4: full 512-byte block of 0xFF.
    task automatic t_big_block();
        new_case();
        blk(8'hFE, 512, 0, 1); resp(0, 8'h05); busyw(8'h00, 4);
        run(1, 512, 0, 0, 8'h00, "R4_big");
    endtask

    // R10: zero block count in both modes.
    task automatic t_zero_count();
        new_case();
        run(0, 4, 0, 0, 8'h00, "R10_single");
        new_case();
        stop_seq(); busyw(8'hFF, 1);
        run(0, 4, 1, 0, 8'h00, "R10_multi");
    endtask

    // R9: a second start while busy must not disturb the transfer.
    task automatic t_ignore_start();
        new_case();
        for (int b = 0; b < 2; b++) begin
            blk(8'hFC, 6, 60 + b, 0); resp(0, 8'h05); busyw(8'h00, 1);
        end
        stop_seq(); busyw(8'h00, 0);
        run(2, 6, 1, 1, 8'h00, "R9_restart");
    endtask

    initial begin
        t_reset();
        t_single();
        t_multi_gaps();
        t_crc_reject();
        t_write_err();
        t_no_resp();
        t_busy_tmo();
        t_stop_tmo();
        t_big_block();
        t_zero_count();
        t_ignore_start();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule